// File: doc/BRIEF.md
# SMBus Register Slave with Shared Broadcast Address

This block connects a bank of sixteen 8-bit registers to a two-wire SMBus host. The system clock samples SCL and SDA, and the block runs its whole protocol on events found in those samples. It detects start, repeated-start and stop conditions. It compares each address byte with two values: its own strapped address and a broadcast address that every device on the bus shares. It acknowledges the bytes it accepts and moves register contents in both directions. The block drives SDA only through an active-high pull-low enable, which feeds an open-drain pad. SCL is an input only, so the block never stretches the clock.

The own address is four fixed high bits followed by three low bits. A pre-decoded three-level strap code sets two of the low bits. Bit 1 of register 4 sets the third. The broadcast address is all zeros and is accepted for writes only. A host can therefore switch several devices with one transfer, and no device can collide with another on a reply. In a write, the first byte after the address loads the register pointer and each later byte is written at that pointer. In a read, bytes come from the pointer, MSB first. The pointer advances after every byte and wraps at the top of the bank. Bit 0 of register 0 appears on a power-enable pin.

Each accepted data byte is presented on a write port as a one-cycle valid pulse. The bus gives no way to hold a byte back, so the port has no ready signal: the consumer must take every beat in the cycle it appears.

Top module: `smb_regslave`

## Requirements
- R1: SDA falling while SCL is high is a start, and at any time it begins a new address phase. SDA rising while SCL is high is a stop, and it returns the block to idle. After either condition, SDA is released.
- R2: The own address is 1010, then A2, then A1:A0. A2 is bit 1 of register 4. A1:A0 comes from the strap code: 00 (low) gives 00, 01 (floating) gives 01, 10 (high) gives 10, and the unused code 11 is treated like low. The address byte is sent MSB first, and its last bit is the direction (0 write, 1 read).
- R3: Address 0000000 is acknowledged with direction 0, and its writes act exactly like writes to the own address. With direction 1 it is never acknowledged, and SDA is never pulled low during the byte that follows.
- R4: An address byte that matches neither address gets no acknowledge, and SDA is never pulled low until the next start.
- R5: The first byte after a write address loads the register pointer from its low four bits. The upper bits are ignored.
- R6: Each later byte of a write appears on the write port as a single-cycle valid pulse carrying index = pointer and the byte. The pointer then advances, and wraps from 15 to 0.
- R7: Every byte received after an accepted write address is acknowledged: SDA is held low through the high phase of the ninth clock. SDA changes only after an SCL fall or a bus condition.
- R8: After an accepted read address, the block sends the register at the pointer, MSB first. It advances the pointer after each byte, with the same wrap as R6.
- R9: When the host leaves the ninth bit of a read byte high (no acknowledge), the block releases SDA and drives nothing more until the next start.
- R10: A repeated start in place of a stop ends the current transfer and matches a new address, so a pointer write can be followed directly by a read.
- R11: A byte cut short by a stop or a start is discarded. It produces no write and does not change the pointer.
- R12: After reset all registers are zero, SDA is released and the write port is idle. The power-enable output always equals bit 0 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level, asynchronous |
| sda_i | input | 1 | SDA line level, asynchronous |
| strap_i | input | 2 | Decoded strap: 00 low, 01 floating, 10 high |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| wr_valid_o | output | 1 | One-cycle pulse: a register byte was written |
| wr_idx_o | output | 4 | Register index of the write |
| wr_data_o | output | 8 | Byte written |
| pwr_en_o | output | 1 | Power enable, bit 0 of register 0 |

## Verification
A pin change reaches the protocol logic two clocks later, through the synchronizer. The reaction (the SDA pull, a write pulse, a pointer step) is registered on the clock after that. This puts every result about three clocks behind the SCL edge that causes it. The power-enable pin follows one clock after the write pulse. The bench moves one bus line at a time and waits eight clocks after each move. It samples the acknowledge bit and the read data in the middle of the SCL high phase, and checks the write port only after the acknowledge clock has finished. At every sampling point the due result has therefore been stable for several cycles.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 7;

  localparam logic [1:0] STRAP_LOW   = 2'b00;
  localparam logic [1:0] STRAP_FLOAT = 2'b01;
  localparam logic [1:0] STRAP_HIGH  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT
  } link_state_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_CMD,
    ROLE_DATA
  } byte_role_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_N-1:0] scl_ff;
  logic [SYNC_N-1:0] sda_ff;
  logic scl_q, sda_q, scl_s;

  // Idle bus is high: reset the chains to 1 so no false event follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_N-1];
      sda_q  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s    = scl_ff[SYNC_N-1];
  assign sda_s    = sda_ff[SYNC_N-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA may only move with SCL high when it is a bus condition.
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_addr_sel.sv
module smb_addr_sel
  import smb_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1010
) (
  input  logic [1:0]       strap,
  input  logic             a2,
  output logic [ADR_W-1:0] own_addr
);
  logic [1:0] low_bits;

  always_comb begin
    case (strap)
      STRAP_FLOAT: low_bits = 2'b01;
      STRAP_HIGH:  low_bits = 2'b10;
      default:     low_bits = 2'b00; // low strap, and the unused code
    endcase
  end

  assign own_addr = {ADDR_HI, a2, low_bits};
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int REG_N   = 16,
  parameter int IDX_W   = 4,
  parameter int CFG_IDX = 4,
  parameter int CFG_BIT = 1,
  parameter int PWR_IDX = 0,
  parameter int PWR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rdata,
  output logic              cfg_a2,
  output logic              pwr_bit
);
  logic [BYTE_W-1:0] regs [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && widx == IDX_W'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata   = regs[ridx];
  assign cfg_a2  = regs[CFG_IDX][CFG_BIT];
  assign pwr_bit = regs[PWR_IDX][PWR_BIT];
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter int               REG_N      = 16,
  parameter int               IDX_W      = 4,
  parameter logic [ADR_W-1:0] BCAST_ADDR = 7'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADR_W-1:0]  own_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              sda_pull,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  link_state_t       state;
  byte_role_t        role;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  ptr;
  logic              rd_dir;

  function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(REG_N - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [ADR_W-1:0] rx_addr;
  logic             rx_rw;
  logic             addr_hit;
  assign rx_addr  = shreg[BYTE_W-1:1];
  assign rx_rw    = shreg[0];
  assign addr_hit = (rx_addr == own_addr) || (rx_addr == BCAST_ADDR && !rx_rw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      role     <= ROLE_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      rd_dir   <= 1'b0;
      sda_pull <= 1'b0;
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_ev) begin
        state    <= ST_RX;
        role     <= ROLE_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              case (role)
                ROLE_ADDR: begin
                  if (addr_hit) begin
                    sda_pull <= 1'b1;
                    rd_dir   <= rx_rw;
                    state    <= ST_RX_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ROLE_CMD: begin
                  ptr      <= shreg[IDX_W-1:0];
                  sda_pull <= 1'b1;
                  state    <= ST_RX_ACK;
                end
                default: begin
                  wr_valid <= 1'b1;
                  wr_idx   <= ptr;
                  wr_data  <= shreg;
                  ptr      <= ptr_step(ptr);
                  sda_pull <= 1'b1;
                  state    <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (role == ROLE_ADDR && rd_dir) begin
                shreg    <= rd_data;
                sda_pull <= ~rd_data[BYTE_W-1];
                state    <= ST_TX;
              end else begin
                sda_pull <= 1'b0;
                role     <= (role == ROLE_ADDR) ? ROLE_CMD : ROLE_DATA;
                state    <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                ptr      <= ptr_step(ptr);
                state    <= ST_TX_ACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_pull <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise)
              state <= sda_s ? ST_IDLE : ST_TX_NEXT;
          end
          ST_TX_NEXT: begin
            if (scl_fall) begin
              bitcnt   <= '0;
              shreg    <= rd_data;
              sda_pull <= ~rd_data[BYTE_W-1];
              state    <= ST_TX;
            end
          end
          ST_IDLE: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_idx = ptr;
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
  import smb_pkg::*;
#(
  parameter int               REG_N      = 16,
  parameter int               SYNC_N     = 2,
  parameter logic [3:0]       ADDR_HI    = 4'b1010,
  parameter logic [ADR_W-1:0] BCAST_ADDR = 7'h00,
  parameter int               CFG_IDX    = 4,
  parameter int               CFG_BIT    = 1,
  parameter int               PWR_IDX    = 0,
  parameter int               PWR_BIT    = 0,
  localparam int              IDX_W      = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              pwr_en_o
);
  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              cfg_a2;
  logic [ADR_W-1:0]  own_addr;
  logic [IDX_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] rd_data;

  smb_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_addr_sel #(.ADDR_HI(ADDR_HI)) u_addr (
    .strap(strap_i), .a2(cfg_a2), .own_addr(own_addr)
  );

  smb_link #(.REG_N(REG_N), .IDX_W(IDX_W), .BCAST_ADDR(BCAST_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr), .rd_data(rd_data), .rd_idx(rd_idx),
    .sda_pull(sda_pull_o), .wr_valid(wr_valid_o),
    .wr_idx(wr_idx_o), .wr_data(wr_data_o)
  );

  smb_regbank #(
    .REG_N(REG_N), .IDX_W(IDX_W), .CFG_IDX(CFG_IDX), .CFG_BIT(CFG_BIT),
    .PWR_IDX(PWR_IDX), .PWR_BIT(PWR_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_valid_o), .widx(wr_idx_o),
    .wdata(wr_data_o), .ridx(rd_idx), .rdata(rd_data),
    .cfg_a2(cfg_a2), .pwr_bit(pwr_en_o)
  );
endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk #(
  parameter int IDX_W   = 4,
  parameter int PWR_IDX = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             sda_pull,
  input logic             wr_valid,
  input logic [IDX_W-1:0] wr_idx,
  input logic             pwr_en
);
  // R7: the pull enable moves only on the clock after an SCL fall or a bus condition
  a_r7_pull_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_ev || stop_ev));

  // R1: a stop or a start releases SDA
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull);
  a_r1_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_pull);

  // R6: the write pulse lasts one cycle and follows an SCL fall
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r6_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(scl_fall));

  // R12: power enable changes only after a write to its register
  a_r12_pwr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en != $past(pwr_en)) |-> $past(wr_valid && wr_idx == IDX_W'(PWR_IDX)));
endmodule

bind smb_regslave smb_regslave_chk #(.IDX_W(IDX_W), .PWR_IDX(PWR_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_pull(sda_pull_o), .wr_valid(wr_valid_o),
  .wr_idx(wr_idx_o), .pwr_en(pwr_en_o)
);

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       sda_pull, wr_valid, pwr_en;
  logic [3:0] wr_idx;
  logic [7:0] wr_data;
  wire        sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  smb_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .sda_pull_o(sda_pull), .wr_valid_o(wr_valid),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .pwr_en_o(pwr_en)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  logic [3:0] last_idx = '0;
  logic [7:0] last_dat = '0;
  logic [7:0] mreg [16];
  logic [3:0] mptr = '0;

  always @(posedge clk) begin
    if (rst_n && wr_valid) begin
      wr_cnt   = wr_cnt + 1;
      last_idx = wr_idx;
      last_dat = wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_own(input logic [1:0] s, input logic a2);
    logic [1:0] lo;
    lo = (s == 2'd2) ? 2'd2 : (s == 2'd1) ? 2'd1 : 2'd0;
    return {4'b1010, a2, lo};
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q();
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_bus; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~mack);
  endtask

  // write cmd then n bytes of seed + 29*k; checks acks and the write port
  task automatic wr_seq(input logic [6:0] a, input logic [7:0] cmd, input int n,
                        input logic [7:0] seed);
    logic ack;
    logic [7:0] d;
    int prev;
    bus_start();
    send_byte({a, 1'b0}, ack);
    check("R2 R3 write address ack", ack, 1'b1);
    send_byte(cmd, ack);
    check("R7 pointer byte ack", ack, 1'b1);
    mptr = cmd[3:0];
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 29);
      prev = wr_cnt;
      send_byte(d, ack);
      check("R7 data byte ack", ack, 1'b1);
      check("R6 one write pulse", wr_cnt, prev + 1);
      check("R6 R5 write index", last_idx, mptr);
      check("R6 write data", last_dat, d);
      mreg[mptr] = d;
      mptr = mptr + 4'd1;
    end
    bus_stop();
  endtask

  task automatic probe(input logic [6:0] a, input logic expect_ack, input string tag);
    logic ack;
    bus_start();
    send_byte({a, 1'b0}, ack);
    check(tag, ack, expect_ack);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic       ack, b;
    logic [7:0] v;
    logic [6:0] own;
    int         prev;
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    repeat (5) @(negedge clk);
    check("R12 reset pull", sda_pull, 1'b0);
    check("R12 reset pwr", pwr_en, 1'b0);
    check("R12 reset write port", wr_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Sweep every address in both directions: strap low, A2 = 0
    own = exp_own(2'd0, 1'b0);
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        bus_start();
        send_byte({7'(a), 1'(rw)}, ack);
        check("R2 R3 R4 address sweep ack", ack,
              (7'(a) == own) || (a == 0 && rw == 0));
        if (ack && rw == 1) begin
          recv_byte(v, 1'b0);
          check("R8 read at pointer", v, mreg[mptr]);
          mptr = mptr + 4'd1;
        end else if (a == 0 && rw == 1) begin
          recv_byte(v, 1'b0);
          check("R3 broadcast read leaves SDA high", v, 8'hFF);
        end else if (a == 1 && rw == 1) begin
          recv_byte(v, 1'b0);
          check("R4 foreign read leaves SDA high", v, 8'hFF);
        end
        bus_stop();
      end
    end

    // Address selection over A2 and every strap code
    for (int a2 = 0; a2 < 2; a2++) begin
      wr_seq(7'h00, 8'h04, 1, (a2 == 1) ? 8'h02 : 8'h00);
      for (int s = 0; s < 4; s++) begin
        strap = 2'(s);
        probe(exp_own(2'(s), 1'(a2)), 1'b1, "R2 own address accepted");
        probe(exp_own(2'(s), ~1'(a2)), 1'b0, "R2 other A2 refused");
      end
    end
    wr_seq(7'h00, 8'h04, 1, 8'h00);
    check("R3 broadcast write landed", mreg[4], 8'h00);

    // Multi-byte write with pointer wrap; pointer byte upper bits ignored
    strap = 2'd1;
    own = exp_own(2'd1, 1'b0);
    wr_seq(own, 8'hFE, 4, 8'h47);
    check("R12 pwr follows reg0 bit0", pwr_en, mreg[0][0]);

    // Pointer write, repeated start, multi-byte read across the wrap
    bus_start();
    send_byte({own, 1'b0}, ack);
    send_byte(8'h0D, ack);
    mptr = 4'hD;
    bus_start();
    send_byte({own, 1'b1}, ack);
    check("R10 read after repeated start ack", ack, 1'b1);
    for (int k = 0; k < 5; k++) begin
      recv_byte(v, k < 4);
      check("R8 R6 read sequence wraps", v, mreg[mptr]);
      mptr = mptr + 4'd1;
    end
    repeat (4) @(negedge clk);
    check("R9 released after no-ack", sda_pull, 1'b0);
    get_bit(b);
    check("R9 silent until next start", b, 1'b1);
    bus_stop();

    // Partial byte ended by stop
    prev = wr_cnt;
    bus_start();
    send_byte({own, 1'b0}, ack);
    send_byte(8'h03, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    check("R11 no write from cut byte", wr_cnt, prev);
    // Partial byte ended by repeated start, then read at pointer
    bus_start();
    send_byte({own, 1'b0}, ack);
    send_byte(8'h06, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_start();
    send_byte({own, 1'b1}, ack);
    check("R10 R1 start mid-byte rematches", ack, 1'b1);
    recv_byte(v, 1'b0);
    check("R11 pointer unchanged by cut byte", v, mreg[6]);
    bus_stop();
    check("R11 no write from cut byte", wr_cnt, prev);
    bus_start();
    send_byte({own, 1'b0}, ack);
    send_byte(8'h03, ack);
    bus_start();
    send_byte({own, 1'b1}, ack);
    recv_byte(v, 1'b0);
    check("R11 register kept old value", v, mreg[3]);
    bus_stop();

    // Power enable through broadcast writes
    wr_seq(7'h00, 8'h00, 1, 8'h01);
    check("R12 pwr set", pwr_en, 1'b1);
    wr_seq(7'h00, 8'h00, 1, 8'hFE);
    check("R12 pwr clear", pwr_en, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule